// File: doc/BRIEF.md
# GPIO SMI Event Status Bank

This block holds one event status bit per general-purpose input pad of a GPIO community and turns those bits into one System Management Interrupt request. Every pad delivers a level event that has already been through edge or level selection and polarity inversion. It also delivers a GPIO-input-mode flag, a three-bit owner code and a route-to-SMI control bit. A status bit records an event only when its pad is in GPIO input mode and the host firmware owns it (owner code 000).

Software reaches the bank through a 32-bit register port with two words: the status word and an enable word. A pad raises an SMI when three things hold together: its status bit, its enable bit and its route bit. The enable bit only gates the request. It never stops a status bit from recording. The status word is sparse. Bits 14, 20 and 23 are write-1-to-clear event bits. Bit 24 is a read-only live view. Every other bit reads zero.

Top module: `gpi_smi_stat`

## Requirements
- R1: After reset, the status word, the enable word, the read data and `smi_req` are all 0.
- R2: A status bit for pad n sets when three conditions hold in the same cycle: `pad_level_evt[n]` is 1, `pad_gpi_mode[n]` is 1, and the owner field `pad_owner[3n+2:3n]` is 3'b000. The bit shows on the clock edge that samples these conditions. If any one condition is missing, the bit does not set.
- R3: The enable word does not affect whether a status bit sets. A pad whose enable bit is 0 still records its event in the status word.
- R4: `smi_req` is 1 only when some pad has its status bit, its enable bit and its `pad_route_smi` bit all at 1. A pad with only two of the three raises no request.
- R5: The status word is at word address 0. Writing 1 to bit 14, 20 or 23 there clears that bit. Writing 0 leaves the bit unchanged.
- R6: Status bits other than 14, 20, 23 and 24 always read 0, whatever their pad inputs are and whatever is written to them.
- R7: The enable word is at word address 1. It is read/write only in bits 14, 20, 23 and 24. All its other bits read 0.
- R8: When a hardware set and a software clear of the same bit fall in the same cycle, the set wins. A qualified level that is still present therefore keeps the bit at 1 through a clear.
- R9: Status bit 24 shows the qualified event condition of pad 24 as sampled on the last clock edge. Writes to it have no effect, so it clears only when the condition goes away.
- R10: `smi_req` is registered. It rises on the clock edge after the edge on which the status bit, enable bit and route bit first all become 1.
- R11: A read that `reg_rd_en` strobes returns its data on `reg_rdata` one clock later. Word addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_level_evt | input | NUM_PADS | Conditioned level event, one bit per pad |
| pad_gpi_mode | input | NUM_PADS | 1 when the pad is in GPIO input mode |
| pad_owner | input | 3*NUM_PADS | Owner code per pad; 000 means host firmware |
| pad_route_smi | input | NUM_PADS | Per-pad route-to-SMI control |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address: 0 status, 1 enable |
| reg_wdata | input | NUM_PADS | Write data |
| reg_rdata | output | NUM_PADS | Read data, one cycle after the strobe |
| smi_req | output | 1 | Combined SMI request, registered |

## Verification
The bench targets clear attempts made while the qualifying level is still high. A design that let the clear win would lose a live event and drop the request for one cycle. It also drives events on pads whose owner code is not 000 or whose mode bit is 0, and on unimplemented bit positions. A design that skipped the qualifiers would show bits that must stay zero. It writes ones to read-only bit 24 and to unmapped words: a design with a uniform write path would clear the live bit or corrupt the enable word. Finally, it samples `smi_req` exactly one and two cycles after a new event, which catches a request that is left combinational or delayed by an extra stage.

// File: rtl/gpi_smi_pkg.sv
package gpi_smi_pkg;

  localparam int unsigned OWN_W = 3;
  typedef logic [OWN_W-1:0] owner_t;

  // owner code meaning "firmware owns this pad"
  localparam owner_t HOST_OWNER = '0;

  // word addresses on the register port
  localparam int unsigned STS_WORD = 0;
  localparam int unsigned EN_WORD  = 1;

  typedef enum logic [1:0] {
    BIT_ABSENT = 2'd0,
    BIT_W1C    = 2'd1,
    BIT_LIVE   = 2'd2
  } bit_kind_e;

  // a pad event counts only in GPIO input mode with host ownership
  function automatic logic evt_qualified(logic level, logic gpi_mode, owner_t owner);
    return level & gpi_mode & (owner == HOST_OWNER);
  endfunction

  function automatic bit_kind_e kind_of(logic is_w1c, logic is_live);
    if (is_w1c)  return BIT_W1C;
    if (is_live) return BIT_LIVE;
    return BIT_ABSENT;
  endfunction

endpackage

// File: rtl/gpi_smi_cell.sv
module gpi_smi_cell
  import gpi_smi_pkg::*;
#(
  parameter bit_kind_e KIND = BIT_ABSENT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);

  generate
    if (KIND == BIT_W1C) begin : g_w1c
      // sticky bit: hardware set has priority over software clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sts_o <= 1'b0;
        else if (set_i) sts_o <= 1'b1;
        else if (clr_i) sts_o <= 1'b0;
      end
    end else if (KIND == BIT_LIVE) begin : g_live
      logic unused_clr;
      assign unused_clr = clr_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_o <= 1'b0;
        else        sts_o <= set_i;
      end
    end else begin : g_absent
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ set_i ^ clr_i;
      assign sts_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/gpi_smi_regif.sv
module gpi_smi_regif
  import gpi_smi_pkg::*;
#(
  parameter int unsigned       REG_W     = 32,
  parameter int unsigned       ADDR_W    = 2,
  parameter logic [REG_W-1:0]  IMPL_MASK = '0,
  parameter logic [REG_W-1:0]  W1C_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  sts_i,
  output logic [REG_W-1:0]  en_o,
  output logic [REG_W-1:0]  clr_o,
  output logic [REG_W-1:0]  rdata_o
);

  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_WORD);
  localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_WORD);

  function automatic logic [REG_W-1:0] read_mux(logic [ADDR_W-1:0] a,
                                                logic [REG_W-1:0] sts,
                                                logic [REG_W-1:0] en);
    if (a == STS_A) return sts;
    if (a == EN_A)  return en;
    return '0;
  endfunction

  logic wr_sts, wr_en_word;
  assign wr_sts     = wr_i && (addr_i == STS_A);
  assign wr_en_word = wr_i && (addr_i == EN_A);

  assign clr_o = wr_sts ? (wdata_i & W1C_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_o <= '0;
    else if (wr_en_word) en_o <= wdata_i & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= read_mux(addr_i, sts_i, en_o);
  end

endmodule

// File: rtl/gpi_smi_merge.sv
module gpi_smi_merge #(
  parameter int unsigned NUM = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] sts_i,
  input  logic [NUM-1:0] en_i,
  input  logic [NUM-1:0] route_i,
  output logic [NUM-1:0] req_vec_o,
  output logic           smi_o
);

  assign req_vec_o = sts_i & en_i & route_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_o <= 1'b0;
    else        smi_o <= |req_vec_o;
  end

endmodule

// File: rtl/gpi_smi_stat.sv
module gpi_smi_stat
  import gpi_smi_pkg::*;
#(
  parameter int unsigned          NUM_PADS  = 32,
  parameter int unsigned          ADDR_W    = 2,
  parameter logic [NUM_PADS-1:0]  W1C_MASK  = 32'h0090_4000,
  parameter logic [NUM_PADS-1:0]  LIVE_MASK = 32'h0100_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PADS-1:0]       pad_level_evt,
  input  logic [NUM_PADS-1:0]       pad_gpi_mode,
  input  logic [NUM_PADS*OWN_W-1:0] pad_owner,
  input  logic [NUM_PADS-1:0]       pad_route_smi,
  input  logic                      reg_wr_en,
  input  logic                      reg_rd_en,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [NUM_PADS-1:0]       reg_wdata,
  output logic [NUM_PADS-1:0]       reg_rdata,
  output logic                      smi_req
);

  localparam logic [NUM_PADS-1:0] IMPL_MASK = W1C_MASK | LIVE_MASK;

  // named internal events, visible to the bound checker
  logic [NUM_PADS-1:0] set_hit;
  logic [NUM_PADS-1:0] clr_hit;
  logic [NUM_PADS-1:0] sts_q;
  logic [NUM_PADS-1:0] en_q;
  logic [NUM_PADS-1:0] smi_vec;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign set_hit[p] = IMPL_MASK[p] &
                        evt_qualified(pad_level_evt[p], pad_gpi_mode[p],
                                      pad_owner[p*OWN_W +: OWN_W]);

    gpi_smi_cell #(
      .KIND (kind_of(W1C_MASK[p], LIVE_MASK[p]))
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_hit[p]),
      .clr_i (clr_hit[p]),
      .sts_o (sts_q[p])
    );
  end

  gpi_smi_regif #(
    .REG_W     (NUM_PADS),
    .ADDR_W    (ADDR_W),
    .IMPL_MASK (IMPL_MASK),
    .W1C_MASK  (W1C_MASK)
  ) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_en),
    .rd_i    (reg_rd_en),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .sts_i   (sts_q),
    .en_o    (en_q),
    .clr_o   (clr_hit),
    .rdata_o (reg_rdata)
  );

  gpi_smi_merge #(
    .NUM (NUM_PADS)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_i     (sts_q),
    .en_i      (en_q),
    .route_i   (pad_route_smi),
    .req_vec_o (smi_vec),
    .smi_o     (smi_req)
  );

endmodule

// File: rtl/gpi_smi_chk.sv
module gpi_smi_chk #(
  parameter int unsigned     NUM       = 32,
  parameter logic [NUM-1:0]  W1C_MASK  = '0,
  parameter logic [NUM-1:0]  LIVE_MASK = '0
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NUM-1:0] set_hit,
  input logic [NUM-1:0] clr_hit,
  input logic [NUM-1:0] sts_q,
  input logic [NUM-1:0] en_q,
  input logic [NUM-1:0] smi_vec,
  input logic           smi_req,
  input logic           rd_en,
  input logic [NUM-1:0] rdata
);

  localparam logic [NUM-1:0] IMPL = W1C_MASK | LIVE_MASK;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_hit) |=> ((sts_q & $past(set_hit)) == $past(set_hit)));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_hit & ~set_hit)) |=> ((sts_q & $past(clr_hit & ~set_hit)) == '0));

  // R9
  live_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((sts_q & LIVE_MASK) == ($past(set_hit) & LIVE_MASK)));

  // R6
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rd_en)) |-> ((rdata & ~IMPL) == '0));

  // R7
  en_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~IMPL) == '0));

  // R10
  smi_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (smi_req == $past(|smi_vec)));

  // R4
  smi_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && smi_req) |-> $past(|(sts_q & en_q)));

endmodule

bind gpi_smi_stat gpi_smi_chk #(
  .NUM       (NUM_PADS),
  .W1C_MASK  (W1C_MASK),
  .LIVE_MASK (LIVE_MASK)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .set_hit (set_hit),
  .clr_hit (clr_hit),
  .sts_q   (sts_q),
  .en_q    (en_q),
  .smi_vec (smi_vec),
  .smi_req (smi_req),
  .rd_en   (reg_rd_en),
  .rdata   (reg_rdata)
);

// File: tb/gpi_smi_stat_bench.sv
`timescale 1ns/100ps
module gpi_smi_stat_bench;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pad_level_evt = '0;
  logic [N-1:0]  pad_gpi_mode = '0;
  logic [N*3-1:0] pad_owner;
  logic [N-1:0]  pad_route_smi = '0;
  logic          reg_wr_en = 1'b0;
  logic          reg_rd_en = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          smi_req;

  always #2.5 clk = ~clk;

  gpi_smi_stat u_gpi_smi_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .pad_level_evt (pad_level_evt),
    .pad_gpi_mode  (pad_gpi_mode),
    .pad_owner     (pad_owner),
    .pad_route_smi (pad_route_smi),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .smi_req       (smi_req)
  );

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rd_v = 1'b0;

  // monitor: a read strobed before an edge returns data after it
  always @(posedge clk) rd_v <= rst_n && reg_rd_en;

  always @(negedge clk) begin
    if (rd_v) begin
      rd_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL R11: read data with no expected item, actual=%h", reg_rdata);
      end else begin
        it = sb_q.pop_front();
        if (reg_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s: rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, logic [N-1:0] exp, string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    reg_rd_en = 1'b1;
    reg_addr  = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic chk_smi(logic exp, string tag);
    checks++;
    if (smi_req !== exp) begin
      failures++;
      $display("FAIL %s: smi_req actual=%b expected=%b", tag, smi_req, exp);
    end
  endtask

  task automatic set_owner(int p, logic [2:0] v);
    pad_owner[p*3 +: 3] = v;
  endtask

  task automatic pad_evt(int p, logic lvl, logic gpi, logic [2:0] own);
    pad_level_evt[p] = lvl;
    pad_gpi_mode[p]  = gpi;
    set_owner(p, own);
  endtask

  initial begin
    for (int p = 0; p < N; p++) pad_owner[p*3 +: 3] = 3'b001;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset values
    rd(2'd0, 32'h0, "R1 status");
    rd(2'd1, 32'h0, "R1 enable");
    chk_smi(1'b0, "R1");

    // R2 wrong owner, then wrong mode
    pad_evt(14, 1'b1, 1'b1, 3'b001);
    step(2);
    rd(2'd0, 32'h0, "R2 owner not host");
    pad_evt(14, 1'b1, 1'b0, 3'b000);
    step(2);
    rd(2'd0, 32'h0, "R2 not input mode");

    // R2/R3/R6 qualified on 14, also on unimplemented pad 5, enable off
    pad_evt(14, 1'b1, 1'b1, 3'b000);
    pad_evt(5, 1'b1, 1'b1, 3'b000);
    step(2);
    rd(2'd0, 32'h0000_4000, "R2 R3 R6 set with enable clear");
    chk_smi(1'b0, "R4 enable clear");

    // R7 enable mask
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0190_4000, "R7 implemented enable bits");
    wr(2'd1, 32'h0000_4000);
    rd(2'd1, 32'h0000_4000, "R7 readback");

    // R4 route gate
    step(2);
    chk_smi(1'b0, "R4 route clear");
    pad_route_smi[14] = 1'b1;
    step(1);
    chk_smi(1'b1, "R4 all three set");

    // R8 clear while level still present
    wr(2'd0, 32'h0000_4000);
    rd(2'd0, 32'h0000_4000, "R8 set wins");
    chk_smi(1'b1, "R8 request kept");

    // R5 write 0 no effect, write 1 clears
    pad_evt(14, 1'b0, 1'b1, 3'b000);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, 32'h0000_4000, "R5 write zero");
    wr(2'd0, 32'h0000_4000);
    rd(2'd0, 32'h0000_0000, "R5 write one clears");
    chk_smi(1'b0, "R4 status cleared");

    // R3 event on 20 with enable bit 20 clear
    pad_evt(20, 1'b1, 1'b1, 3'b000);
    step(2);
    pad_evt(20, 1'b0, 1'b1, 3'b000);
    rd(2'd0, 32'h0010_0000, "R3 bit20 records");
    chk_smi(1'b0, "R4 bit20 not enabled");

    // R10 latency on pad 23
    wr(2'd1, 32'h0090_4000);
    wr(2'd0, 32'h0010_0000);
    pad_route_smi[20] = 1'b1;
    pad_route_smi[23] = 1'b1;
    step(2);
    chk_smi(1'b0, "R10 idle before event");
    pad_evt(23, 1'b1, 1'b1, 3'b000);
    step(1);
    chk_smi(1'b0, "R10 not combinational");
    step(1);
    chk_smi(1'b1, "R10 one cycle later");
    wr(2'd0, 32'h0080_0000);
    rd(2'd0, 32'h0080_0000, "R8 bit23 held by level");

    // R9 live bit 24
    pad_evt(23, 1'b0, 1'b1, 3'b000);
    wr(2'd0, 32'h0080_0000);
    pad_evt(24, 1'b1, 1'b1, 3'b000);
    step(2);
    rd(2'd0, 32'h0100_0000, "R9 live bit set");
    wr(2'd0, 32'h0100_0000);
    rd(2'd0, 32'h0100_0000, "R9 write ignored");
    pad_evt(24, 1'b0, 1'b1, 3'b000);
    step(2);
    rd(2'd0, 32'h0000_0000, "R9 follows level");

    // R11 unmapped words
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0, "R11 word2 reads zero");
    rd(2'd3, 32'h0, "R11 word3 reads zero");
    rd(2'd1, 32'h0090_4000, "R11 enable untouched");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule